// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is a half-duplex serial port for I/O expansion. It moves 8-bit frames over one data line and drives the shift clock on a second line. All of its timing comes from a machine-cycle sequencer. One machine cycle is 12 clocks of the input clock. It is divided into six states of two phases each.

Each clock of a machine cycle is a slot numbered 0 to 11. Slot = 2*(state-1) + (phase-1), so S1P1 is slot 0, S3P1 is slot 4, S3P2 is slot 5, S6P1 is slot 10 and S6P2 is slot 11. Exactly one bit moves per machine cycle, so the bit rate is one twelfth of the input clock.

A host writes the transmit buffer to send a byte. It writes a 3-bit control word to enable reception and to set or clear the two completion flags. The byte from the last receive can be read at any time on a read port.

The data line is split into an output value, an output enable and an input value. A pad or the next level of the chip joins them into one bidirectional pin.

Top module: `sync_shift_port`

## Requirements
- R1: After reset, `sclk_o` is 1, `sd_oe` is 0, `sd_o` is 1, `ren_o`, `ti_o` and `ri_o` are 0, and `buf_rdata` is 0. Slot 0 is the first clock after reset is released, and slots then count 0..11 without a break.
- R2: During each of the 8 bit cycles of a frame, `sclk_o` is 0 in slots 5 through 10 and 1 in slots 11 and 0 through 4. Outside a frame it stays 1.
- R3: A buffer write accepted while idle starts a transmit frame at the first slot-11 clock edge after the write. From slot 0 of the next cycle, `sd_oe` is 1 and `sd_o` carries bit 0. Bit k is held for the whole of bit cycle k+1 (k = 0..7), and bits change only at machine-cycle boundaries.
- R4: At the end of bit cycle 8 of a transmit frame, `sd_oe` returns to 0 and `sd_o` returns to 1 from slot 0. `ti_o` becomes 1 in slot 4 of that same machine cycle.
- R5: A buffer write is ignored while a transmit is pending (accepted but not yet started) or while any frame runs. The frame carries the first value, and no extra frame follows.
- R6: A receive frame starts at a slot-11 edge when the port is idle, no transmit is pending, `ren_o` is 1 and `ri_o` is 0. Setting the enable, clearing the receive flag, or doing both in one control write all make this condition true. `sd_oe` stays 0 throughout reception.
- R7: `sd_i` is sampled at the clock edge that ends slot 10, just before the shift clock rises. Bits arrive LSB first. After the eighth bit, `buf_rdata` holds the byte from slot 0 of the next cycle, and `ri_o` becomes 1 in slot 4 of that cycle.
- R8: A control write loads enable from bit 0, the transmit flag from bit 1 and the receive flag from bit 2. Without a control write, `ti_o` and `ri_o` keep their values. When a hardware flag set and a control write land on the same edge, the hardware set wins.
- R9: While `ri_o` is 1, no receive frame starts, even with the enable set, and the shift clock stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; 12 periods form one machine cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| buf_wr | input | 1 | One-clock pulse that writes the transmit buffer |
| buf_wdata | input | 8 | Byte to transmit |
| ctl_wr | input | 1 | One-clock pulse that writes the control word |
| ctl_wdata | input | 3 | bit0 enable, bit1 transmit flag, bit2 receive flag |
| buf_rdata | output | 8 | Last received byte |
| ren_o | output | 1 | Receive enable |
| ti_o | output | 1 | Transmit-done flag |
| ri_o | output | 1 | Receive-done flag |
| sclk_o | output | 1 | Shift clock line |
| sd_o | output | 1 | Data line output value |
| sd_oe | output | 1 | Data line output enable |
| sd_i | input | 1 | Data line input value |

## Verification
The completion flags are set by hardware at the edge that ends slot 3, and a host control write can arrive on that same edge. The bench issues control writes that clear the flag exactly at slot 3 after both transmit and receive frames, and it expects the flag to read 1 in slot 4. A buffer write can also coincide with a running or pending transmit. The bench writes during bit cycle 3 and just after an accepted write, then checks that the serial data equals the first byte and that the line stays released afterwards.

// File: rtl/ssp_pkg.sv
// Shared constants and types for the synchronous shift port.
// Assumes a machine cycle of SSP_STATES states with SSP_PHASES phases each.
package ssp_pkg;
    localparam int unsigned SSP_WIDTH  = 8;
    localparam int unsigned SSP_STATES = 6;
    localparam int unsigned SSP_PHASES = 2;
    localparam int unsigned SSP_TICKS  = SSP_STATES * SSP_PHASES;
    localparam int unsigned SSP_TW     = $clog2(SSP_TICKS);

    // Slot index of a given state (1-based) and phase (1-based).
    function automatic int unsigned ssp_slot(int unsigned st, int unsigned ph);
        return (st - 1) * SSP_PHASES + (ph - 1);
    endfunction

    localparam int unsigned SSP_SLOT_LOW_FIRST = ssp_slot(3, 2);
    localparam int unsigned SSP_SLOT_SAMPLE    = ssp_slot(6, 1);
    localparam int unsigned SSP_SLOT_LAST      = SSP_TICKS - 1;
    localparam int unsigned SSP_SLOT_FLAG_SEEN = ssp_slot(3, 1);
    localparam int unsigned SSP_SLOT_FLAG_EDGE = SSP_SLOT_FLAG_SEEN - 1;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_TX   = 2'd1,
        MODE_RX   = 2'd2
    } ssp_mode_e;
endpackage

// File: rtl/ssp_seq.sv
// Machine-cycle sequencer: counts slots 0..SSP_TICKS-1 and decodes the
// strobes the shift engine and flag logic use. Assumes one slot per clock.
module ssp_seq
    import ssp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    output logic [SSP_TW-1:0] tick,
    output logic              at_sample,
    output logic              at_shift,
    output logic              at_flag,
    output logic              low_win
);
    // Slot counter, wraps at the end of each machine cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tick <= '0;
        else if (tick == SSP_TW'(SSP_SLOT_LAST))
            tick <= '0;
        else
            tick <= tick + 1'b1;
    end

    // Strobe decode for the slots that carry behaviour.
    always_comb begin
        at_sample = (tick == SSP_TW'(SSP_SLOT_SAMPLE));
        at_shift  = (tick == SSP_TW'(SSP_SLOT_LAST));
        at_flag   = (tick == SSP_TW'(SSP_SLOT_FLAG_EDGE));
        low_win   = (tick >= SSP_TW'(SSP_SLOT_LOW_FIRST)) &&
                    (tick <= SSP_TW'(SSP_SLOT_SAMPLE));
    end
endmodule

// File: rtl/ssp_ctrl.sv
// Control and flag register: holds the receive enable and both completion
// flags. Hardware sets a flag at the first flag slot after a frame ends and
// wins over a host write on the same edge. Assumes done pulses last one clock.
module ssp_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic [2:0] ctl_wdata,
    input  logic       tx_done,
    input  logic       rx_done,
    input  logic       at_flag,
    output logic       ren,
    output logic       ti,
    output logic       ri,
    output logic       rx_ok
);
    logic tx_fpend;
    logic rx_fpend;

    // Remember a finished frame until the next flag slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_fpend <= 1'b0;
            rx_fpend <= 1'b0;
        end else begin
            if (tx_done)      tx_fpend <= 1'b1;
            else if (at_flag) tx_fpend <= 1'b0;
            if (rx_done)      rx_fpend <= 1'b1;
            else if (at_flag) rx_fpend <= 1'b0;
        end
    end

    // Enable and flags: hardware set first, then host write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ren <= 1'b0;
            ti  <= 1'b0;
            ri  <= 1'b0;
        end else begin
            if (ctl_wr) ren <= ctl_wdata[0];
            if (tx_fpend && at_flag) ti <= 1'b1;
            else if (ctl_wr)         ti <= ctl_wdata[1];
            if (rx_fpend && at_flag) ri <= 1'b1;
            else if (ctl_wr)         ri <= ctl_wdata[2];
        end
    end

    // Receive may start only with enable set and no flag set or due.
    assign rx_ok = ren && !ri && !rx_fpend;
endmodule

// File: rtl/ssp_engine.sv
// Shift engine: one shift register serves both directions. Frames start at
// the last slot of a machine cycle, move one bit per cycle LSB first and end
// after WIDTH cycles. Assumes strobes from ssp_seq; transmit beats receive.
module ssp_engine
    import ssp_pkg::*;
#(
    parameter int unsigned WIDTH = SSP_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             at_sample,
    input  logic             at_shift,
    input  logic             low_win,
    input  logic             buf_wr,
    input  logic [WIDTH-1:0] buf_wdata,
    input  logic             rx_ok,
    input  logic             sd_i,
    output ssp_mode_e        mode,
    output logic             sd_o,
    output logic             sd_oe,
    output logic             sclk,
    output logic             tx_done,
    output logic             rx_done,
    output logic [WIDTH-1:0] rx_buf
);
    localparam int unsigned CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

    logic             tx_pend;
    logic [WIDTH-1:0] tx_hold;
    logic [WIDTH-1:0] shreg;
    logic [CW-1:0]    bcnt;
    logic             last_bit;
    logic             wr_take;
    logic             idle;

    assign idle     = (mode == MODE_IDLE);
    assign last_bit = (bcnt == CW'(WIDTH - 1));
    assign wr_take  = buf_wr && idle && !tx_pend;

    // Hold an accepted transmit byte until the next frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_pend <= 1'b0;
            tx_hold <= '0;
        end else if (wr_take) begin
            tx_pend <= 1'b1;
            tx_hold <= buf_wdata;
        end else if (idle && at_shift && tx_pend) begin
            tx_pend <= 1'b0;
        end
    end

    // Frame mode and bit-cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= MODE_IDLE;
            bcnt <= '0;
        end else if (at_shift) begin
            if (idle) begin
                bcnt <= '0;
                if (tx_pend)    mode <= MODE_TX;
                else if (rx_ok) mode <= MODE_RX;
            end else if (last_bit) begin
                mode <= MODE_IDLE;
            end else begin
                bcnt <= bcnt + 1'b1;
            end
        end
    end

    // Shared shift register: load and shift out, or sample in.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shreg <= '0;
        else if (idle && at_shift && tx_pend)
            shreg <= tx_hold;
        else if (mode == MODE_TX && at_shift && !last_bit)
            shreg <= {1'b1, shreg[WIDTH-1:1]};
        else if (mode == MODE_RX && at_sample)
            shreg <= {sd_i, shreg[WIDTH-1:1]};
    end

    // Frame-end pulses and the receive buffer load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_done <= 1'b0;
            rx_done <= 1'b0;
            rx_buf  <= '0;
        end else begin
            tx_done <= (mode == MODE_TX) && at_shift && last_bit;
            rx_done <= (mode == MODE_RX) && at_shift && last_bit;
            if ((mode == MODE_RX) && at_shift && last_bit)
                rx_buf <= shreg;
        end
    end

    // Line drive: data only in transmit, clock low inside the window.
    always_comb begin
        sd_oe = (mode == MODE_TX);
        sd_o  = (mode == MODE_TX) ? shreg[0] : 1'b1;
        sclk  = !(!idle && low_win);
    end
endmodule

// File: rtl/sync_shift_port.sv
// Top of the synchronous shift port: sequencer, shift engine and control
// register. Assumes host writes are one-clock pulses in the clk domain and
// the data line is joined from sd_o/sd_oe/sd_i outside this block.
module sync_shift_port
    import ssp_pkg::*;
#(
    parameter int unsigned WIDTH = SSP_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             buf_wr,
    input  logic [WIDTH-1:0] buf_wdata,
    input  logic             ctl_wr,
    input  logic [2:0]       ctl_wdata,
    output logic [WIDTH-1:0] buf_rdata,
    output logic             ren_o,
    output logic             ti_o,
    output logic             ri_o,
    output logic             sclk_o,
    output logic             sd_o,
    output logic             sd_oe,
    input  logic             sd_i
);
    logic [SSP_TW-1:0] tick;
    logic              at_sample;
    logic              at_shift;
    logic              at_flag;
    logic              low_win;
    logic              rx_ok;
    logic              tx_done;
    logic              rx_done;
    ssp_mode_e         mode;

    ssp_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .at_sample (at_sample),
        .at_shift  (at_shift),
        .at_flag   (at_flag),
        .low_win   (low_win)
    );

    ssp_engine #(.WIDTH(WIDTH)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .at_sample (at_sample),
        .at_shift  (at_shift),
        .low_win   (low_win),
        .buf_wr    (buf_wr),
        .buf_wdata (buf_wdata),
        .rx_ok     (rx_ok),
        .sd_i      (sd_i),
        .mode      (mode),
        .sd_o      (sd_o),
        .sd_oe     (sd_oe),
        .sclk      (sclk_o),
        .tx_done   (tx_done),
        .rx_done   (rx_done),
        .rx_buf    (buf_rdata)
    );

    ssp_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .tx_done   (tx_done),
        .rx_done   (rx_done),
        .at_flag   (at_flag),
        .ren       (ren_o),
        .ti        (ti_o),
        .ri        (ri_o),
        .rx_ok     (rx_ok)
    );
endmodule

// File: rtl/ssp_checker.sv
// Property checker for sync_shift_port, attached by bind below.
// Assumes the slot counter and frame mode of the top are visible by name.
module ssp_checker
    import ssp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [SSP_TW-1:0] tick,
    input ssp_mode_e         mode,
    input logic              sclk_o,
    input logic              sd_o,
    input logic              sd_oe,
    input logic              ti,
    input logic              ri,
    input logic              ctl_wr
);
    // R2: shift clock is high outside the low window slots.
    p_clk_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((tick < SSP_TW'(SSP_SLOT_LOW_FIRST)) || (tick == SSP_TW'(SSP_SLOT_LAST))) |-> sclk_o);

    // R3: data line changes only on the edge that ends the last slot.
    p_data_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick != SSP_TW'(SSP_SLOT_LAST)) |=> ($stable(sd_o) && $stable(sd_oe)));

    // R3: the line is taken only at the start of a machine cycle.
    p_drive_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sd_oe) |-> (tick == '0));

    // R4: transmit flag rises in the flag slot unless written by the host.
    p_ti_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ti) |-> ((tick == SSP_TW'(SSP_SLOT_FLAG_SEEN)) || $past(ctl_wr)));

    // R7: receive flag rises in the flag slot unless written by the host.
    p_ri_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ri) |-> ((tick == SSP_TW'(SSP_SLOT_FLAG_SEEN)) || $past(ctl_wr)));

    // R8: flags hold without a host write.
    p_ti_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ti && !ctl_wr) |=> ti);
    p_ri_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ri && !ctl_wr) |=> ri);

    // R9: a set receive flag keeps reception from starting.
    p_ri_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ri && (mode == MODE_IDLE)) |=> (mode != MODE_RX));

    // R6: the line is never driven during reception.
    p_rx_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RX) |-> !sd_oe);
endmodule

bind sync_shift_port ssp_checker u_ssp_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .mode   (mode),
    .sclk_o (sclk_o),
    .sd_o   (sd_o),
    .sd_oe  (sd_oe),
    .ti     (ti_o),
    .ri     (ri_o),
    .ctl_wr (ctl_wr)
);

// File: tb/test_sync_shift_port.sv
module test_sync_shift_port;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       buf_wr;
    logic [7:0] buf_wdata;
    logic       ctl_wr;
    logic [2:0] ctl_wdata;
    logic [7:0] buf_rdata;
    logic       ren_o, ti_o, ri_o, sclk_o, sd_o, sd_oe, sd_i;

    int total = 0;
    int bad   = 0;
    int tk    = 0;
    int cyc   = 0;

    always #5 clk = ~clk;

    sync_shift_port i_sync_shift_port (
        .clk(clk), .rst_n(rst_n), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .buf_rdata(buf_rdata),
        .ren_o(ren_o), .ti_o(ti_o), .ri_o(ri_o), .sclk_o(sclk_o),
        .sd_o(sd_o), .sd_oe(sd_oe), .sd_i(sd_i)
    );

    // Slot reference from the requirements: 0 after reset, then 0..11.
    always @(posedge clk) begin
        if (!rst_n) tk <= 0;
        else        tk <= (tk == 11) ? 0 : tk + 1;
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL R2 watchdog actual=%0d expected<=150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected serial bit k of a byte, LSB first.
    function automatic logic exp_bit(logic [7:0] v, int k);
        return v[k];
    endfunction

    task automatic goto_tick(int t);
        @(negedge clk);
        while (tk != t) @(negedge clk);
    endtask

    task automatic wr_buf(logic [7:0] v);
        buf_wdata = v;
        buf_wr    = 1'b1;
        @(negedge clk);
        buf_wr    = 1'b0;
    endtask

    task automatic wr_ctl(logic [2:0] v);
        ctl_wdata = v;
        ctl_wr    = 1'b1;
        @(negedge clk);
        ctl_wr    = 1'b0;
    endtask

    // poke: 0 none, 1 write while pending, 2 write during the frame
    task automatic run_tx(logic [7:0] v, int wtick, int poke, bit collide);
        logic [7:0] junk;
        junk = ~v;
        goto_tick(wtick);
        wr_buf(v);
        if (poke == 1) wr_buf(junk);
        goto_tick(0);
        for (int n = 1; n <= 8; n++) begin
            chk("R3", "oe", 32'(sd_oe), 32'd1);
            chk("R3", "data", 32'(sd_o), 32'(exp_bit(v, n - 1)));
            goto_tick(3);
            chk("R2", "clk_hi", 32'(sclk_o), 32'd1);
            goto_tick(5);
            chk("R2", "clk_lo", 32'(sclk_o), 32'd0);
            if (poke == 2 && n == 3) begin
                goto_tick(7);
                wr_buf(junk);
            end
            goto_tick(10);
            chk("R5", "data_kept", 32'(sd_o), 32'(exp_bit(v, n - 1)));
            goto_tick(11);
            chk("R2", "clk_rise", 32'(sclk_o), 32'd1);
            goto_tick(0);
        end
        chk("R4", "oe_off", 32'(sd_oe), 32'd0);
        chk("R4", "data_idle", 32'(sd_o), 32'd1);
        goto_tick(3);
        chk("R4", "ti_early", 32'(ti_o), 32'd0);
        if (collide) begin
            wr_ctl(3'b000);
            chk("R8", "hw_set_wins_ti", 32'(ti_o), 32'd1);
        end else begin
            goto_tick(4);
            chk("R4", "ti_set", 32'(ti_o), 32'd1);
        end
        goto_tick(0);
        chk("R8", "ti_held", 32'(ti_o), 32'd1);
        chk("R5", "no_extra_frame", 32'(sd_oe), 32'd0);
        goto_tick(6);
        chk("R5", "clk_idle", 32'(sclk_o), 32'd1);
        wr_ctl(3'b000);
    endtask

    task automatic run_rx(logic [7:0] v, int wtick, bit via_ri, bit collide);
        if (via_ri) begin
            wr_ctl(3'b101);
            for (int k = 0; k < 2; k++) begin
                goto_tick(6);
                chk("R9", "blocked_clk", 32'(sclk_o), 32'd1);
            end
        end
        goto_tick(wtick);
        wr_ctl(3'b001);
        goto_tick(0);
        for (int n = 1; n <= 8; n++) begin
            chk("R6", "oe_rx", 32'(sd_oe), 32'd0);
            goto_tick(3);
            chk("R2", "clk_hi", 32'(sclk_o), 32'd1);
            goto_tick(5);
            chk("R6", "clk_started", 32'(sclk_o), 32'd0);
            goto_tick(6);
            sd_i = exp_bit(v, n - 1);
            goto_tick(11);
            chk("R7", "clk_rise", 32'(sclk_o), 32'd1);
            sd_i = ~exp_bit(v, n - 1);
            goto_tick(0);
        end
        chk("R7", "rdata", 32'(buf_rdata), 32'(v));
        goto_tick(3);
        chk("R7", "ri_early", 32'(ri_o), 32'd0);
        if (collide) begin
            wr_ctl(3'b001);
            chk("R8", "hw_set_wins_ri", 32'(ri_o), 32'd1);
        end else begin
            goto_tick(4);
            chk("R7", "ri_set", 32'(ri_o), 32'd1);
        end
        for (int k = 0; k < 2; k++) begin
            goto_tick(6);
            chk("R9", "no_restart", 32'(sclk_o), 32'd1);
        end
        chk("R8", "ri_held", 32'(ri_o), 32'd1);
        wr_ctl(3'b000);
    endtask

    initial begin
        rst_n = 1'b0;
        buf_wr = 1'b0; buf_wdata = '0;
        ctl_wr = 1'b0; ctl_wdata = '0;
        sd_i = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "sclk", 32'(sclk_o), 32'd1);
        chk("R1", "oe", 32'(sd_oe), 32'd0);
        chk("R1", "sd_o", 32'(sd_o), 32'd1);
        chk("R1", "flags", 32'({ren_o, ti_o, ri_o}), 32'd0);
        chk("R1", "rdata", 32'(buf_rdata), 32'd0);

        // Directed corners.
        run_tx(8'hA5, 10, 0, 1'b0);
        run_tx(8'h01, 11, 0, 1'b0);
        run_tx(8'h80, 2, 1, 1'b0);
        run_tx(8'h3C, 7, 2, 1'b0);
        run_tx(8'hC6, 0, 0, 1'b1);
        run_rx(8'h5A, 4, 1'b0, 1'b0);
        run_rx(8'hC3, 11, 1'b1, 1'b0);
        run_rx(8'h00, 10, 1'b0, 1'b1);
        run_rx(8'hFF, 1, 1'b1, 1'b0);

        // Constrained random mix with a fixed seed.
        void'($urandom(32'h5EED));
        for (int i = 0; i < 40; i++) begin
            logic [7:0] v;
            int wt, pk;
            v  = 8'($urandom);
            wt = int'($urandom % 12);
            pk = int'($urandom % 3);
            if (pk == 1 && wt > 8) wt = wt - 4;
            if ($urandom % 2 == 0)
                run_tx(v, wt, pk, 1'($urandom % 2));
            else
                run_rx(v, wt, 1'($urandom % 2), 1'($urandom % 2));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule